// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is the device-side control logic of a byte-alterable parallel EEPROM, written as clocked logic. It takes three active-low asynchronous strobes from a host bus (chip select, write strobe and output enable) and passes each through a two-stage synchroniser. From the synchronised strobes it decodes read cycles and write cycles. A write cycle latches an address when it opens and a data byte when it closes. The byte goes into a page buffer. A run of writes to one page fills that buffer, and a byte-load window closes the run. A self-timed programming phase then commits the buffer into a parameterised byte array.

While programming runs, every read returns a status byte and not array contents. Bit 7 holds the inverse of bit 7 of the last byte loaded. Bit 6 flips after every read. A host can therefore poll for completion without a ready pin. A lock input stands for the protected state. While it is high, no write is accepted and no polling status ever appears. The byte-load window and the programming time are parameters counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: `dq_oe` is high exactly when `chip_sel_n` and `out_en_n` were both low two clock edges earlier (two-stage synchroniser). Whenever `dq_oe` is low, `dq_out` is 8'h00.
- R2: Outside programming, a read returns the array byte at the current `addr`. Bytes that are still waiting in the page buffer do not show in a read.
- R3: A write cycle is `chip_sel_n` and `wr_strobe_n` both low while `out_en_n` is high. The address is sampled when the synchronised write condition begins. `dq_in` is sampled when it ends. With all three strobes low, nothing is written.
- R4: A page holds 2**PAGE_W bytes. The page number is `addr[ADDR_W-1:PAGE_W]`, and bits `[PAGE_W-1:0]` select the byte within the page. Any subset of offsets may be loaded, up to the full page. A later load to the same offset replaces the earlier byte.
- R5: A write whose page number differs from the open page is ignored. It changes no buffered byte and does not restart the byte-load window.
- R6: The window counter restarts when an accepted write begins. It counts every cycle in which no accepted write is open. When it has counted LOAD_WIN such cycles, programming starts.
- R7: Programming lasts PROG_CYC cycles. At the end, the loaded bytes are written to the array and the block returns to idle. Writes that arrive during programming are ignored.
- R8: During programming, a read returns {~b7, t, 6'b000000}. Here b7 is bit 7 of the last byte loaded and t is the toggle bit.
- R9: The toggle bit is 0 when programming starts. It inverts at the end of every read made during programming.
- R10: While `wr_lock` is high, no write is accepted, no programming starts, and reads keep returning array data.
- R11: After reset the array holds zeros, the block is idle and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Chip select strobe, active low, asynchronous |
| wr_strobe_n | input | 1 | Write strobe, active low, asynchronous |
| out_en_n | input | 1 | Output enable strobe, active low, asynchronous |
| wr_lock | input | 1 | Protected state: all writes refused |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data driven by the host |
| dq_out | output | 8 | Data or status driven by the block |
| dq_oe | output | 1 | Enable for the tri-state data bus driver |

## Verification
The bench sets ADDR_W=8, PAGE_W=3, LOAD_WIN=24 and PROG_CYC=120. Eight-byte pages make a completely filled page, and writes that cross a page boundary, cheap to reach. A short window allows both a multi-byte load and a gap that closes the page within a few dozen cycles. A 120-cycle programming phase is long enough for several polling reads, so the toggle sequence and the inverted bit 7 can be followed to the moment real data returns.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int LOAD_WIN = 5000,
  parameter int PROG_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic              wr_lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int TW     = $clog2(LOAD_WIN + 1);
  localparam int CW     = $clog2(PROG_CYC + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_LOAD = 2'd1, S_PROG = 2'd2;

  logic [1:0]        cs_q, ws_q, oe_q;
  logic              wr_prev, rd_prev;
  logic [1:0]        state;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              cyc_ok;
  logic [TW-1:0]     timer;
  logic [CW-1:0]     pcnt;
  logic              toggle;
  logic [7:0]        last_q;
  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_N-1:0] vmask;
  logic [7:0]        mem [DEPTH];

  wire wr_act    = !cs_q[1] && !ws_q[1] && oe_q[1];
  wire rd_act    = !cs_q[1] && !oe_q[1];
  wire wr_start  = wr_act && !wr_prev;
  wire wr_end    = !wr_act && wr_prev;
  wire rd_end    = !rd_act && rd_prev;
  wire page_hit  = addr[ADDR_W-1:PAGE_W] == page_q;
  wire accept    = wr_start && !wr_lock &&
                   (state == S_IDLE || (state == S_LOAD && page_hit));
  wire win_done  = state == S_LOAD && !accept && !cyc_ok && timer == TW'(LOAD_WIN - 1);
  wire prog_done = state == S_PROG && pcnt == CW'(PROG_CYC - 1);

  assign dq_oe  = rd_act;
  assign dq_out = !rd_act ? 8'h00 :
                  (state == S_PROG) ? {~last_q[7], toggle, 6'b000000} : mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 2'b11;
      ws_q    <= 2'b11;
      oe_q    <= 2'b11;
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      cs_q    <= {cs_q[0], chip_sel_n};
      ws_q    <= {ws_q[0], wr_strobe_n};
      oe_q    <= {oe_q[0], out_en_n};
      wr_prev <= wr_act;
      rd_prev <= rd_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      page_q <= '0;
      off_q  <= '0;
      cyc_ok <= 1'b0;
      timer  <= '0;
      pcnt   <= '0;
      toggle <= 1'b0;
      last_q <= '0;
      vmask  <= '0;
      for (int i = 0; i < PAGE_N; i++) pbuf[i] <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      if (accept) begin
        cyc_ok <= 1'b1;
        off_q  <= addr[PAGE_W-1:0];
        timer  <= '0;
        if (state == S_IDLE) begin
          page_q <= addr[ADDR_W-1:PAGE_W];
          state  <= S_LOAD;
        end
      end else if (state == S_LOAD && !cyc_ok) begin
        timer <= timer + 1'b1;
      end

      if (wr_end && cyc_ok) begin
        cyc_ok       <= 1'b0;
        pbuf[off_q]  <= dq_in;
        vmask[off_q] <= 1'b1;
        last_q       <= dq_in;
      end

      if (win_done) begin
        state  <= S_PROG;
        pcnt   <= '0;
        toggle <= 1'b0;
      end

      if (state == S_PROG) begin
        pcnt <= pcnt + 1'b1;
        if (rd_end) toggle <= ~toggle;
        if (prog_done) begin
          for (int i = 0; i < PAGE_N; i++)
            if (vmask[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
          vmask <= '0;
          state <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_page_writer_checks.sv
module eeprom_page_writer_checks #(
  parameter int PAGE_W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chip_sel_n,
  input logic                 out_en_n,
  input logic                 wr_lock,
  input logic                 dq_oe,
  input logic [1:0]           state,
  input logic                 prog_done,
  input logic                 rd_end,
  input logic                 toggle,
  input logic                 wr_end,
  input logic                 cyc_ok,
  input logic [(1<<PAGE_W)-1:0] vmask
);
  wire is_prog = state == 2'd2;

  AST_BUS_FROM_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!$past(chip_sel_n, 2) && !$past(out_en_n, 2))); // R1
  AST_PROG_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_prog && !prog_done) |=> is_prog); // R7
  AST_NO_LOAD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    is_prog |-> !cyc_ok); // R7
  AST_PROG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_prog) |-> $past(state) == 2'd1); // R6
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_prog && rd_end) |=> toggle != $past(toggle)); // R9
  AST_MISS_KEEPS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !cyc_ok && !is_prog) |=> vmask == $past(vmask)); // R5
  AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && state == 2'd0) |=> state == 2'd0); // R10
endmodule

bind eeprom_page_writer eeprom_page_writer_checks #(.PAGE_W(PAGE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
  .wr_lock(wr_lock), .dq_oe(dq_oe), .state(state), .prog_done(prog_done),
  .rd_end(rd_end), .toggle(toggle), .wr_end(wr_end), .cyc_ok(cyc_ok),
  .vmask(vmask)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, PW = 3, WIN = 24, PC = 120;
  localparam int PN = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ws_n = 1'b1, oe_n = 1'b1, lock = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dq_out;
  logic dq_oe;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_WIN(WIN), .PROG_CYC(PC)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(cs_n), .wr_strobe_n(ws_n), .out_en_n(oe_n),
    .wr_lock(lock), .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe));

  // behavioural reference
  bit cs1, cs2, ws1, ws2, oe1, oe2, wprev, rprev, open, tog;
  int mode, page, off, waitc, pc;
  bit [7:0] last;
  bit [7:0] mm [0:(1<<AW)-1];
  bit [7:0] pb [0:PN-1];
  bit has [0:PN-1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs1, cs2, ws1, ws2, oe1, oe2} = 6'b111111;
      wprev = 0; rprev = 0; open = 0; tog = 0;
      mode = 0; page = 0; off = 0; waitc = 0; pc = 0; last = 0;
      foreach (mm[k]) mm[k] = 0;
      foreach (pb[k]) begin pb[k] = 0; has[k] = 0; end
    end else begin
      bit w, r, st, en, ok, expire;
      int nmode;
      w = !cs2 && !ws2 && oe2;
      r = !cs2 && !oe2;
      st = w && !wprev;
      en = !w && wprev;
      ok = st && !lock && (mode == 0 || (mode == 1 && (int'(addr) / PN) == page));
      expire = mode == 1 && !ok && !open && waitc == WIN - 1;
      nmode = mode;
      if (mode == 2) begin
        if (!r && rprev) tog = !tog;
        if (pc == PC - 1) begin
          for (int k = 0; k < PN; k++) if (has[k]) begin mm[page*PN + k] = pb[k]; has[k] = 0; end
          nmode = 0;
        end
        pc++;
      end
      if (en && open) begin pb[off] = din; has[off] = 1; last = din; open = 0; end
      if (ok) begin
        if (mode == 0) begin page = int'(addr) / PN; nmode = 1; end
        off = int'(addr) % PN; open = 1; waitc = 0;
      end else if (mode == 1 && !open && !(en)) waitc++;
      else if (mode == 1 && en) waitc++;
      if (expire) begin nmode = 2; pc = 0; tog = 0; end
      mode = nmode;
      wprev = w; rprev = r;
      cs2 = cs1; ws2 = ws1; oe2 = oe1;
      cs1 = cs_n; ws1 = ws_n; oe1 = oe_n;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit r;
    int e;
    r = !cs2 && !oe2;
    e = !r ? 0 : (mode == 2) ? {~last[7], tog, 6'b0} : mm[addr];
    chk("R1 dq_oe", dq_oe, r);
    chk(mode == 2 ? "R8 status" : "R2 read", dq_out, e);
  end

  task automatic cyc(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic wr(int a, int d, bit oe_low = 0);
    cyc(1); addr = AW'(a); din = d[7:0]; cs_n = 0; ws_n = 0; oe_n = oe_low ? 1'b0 : 1'b1;
    cyc(4); cs_n = 1; ws_n = 1; oe_n = 1;
    cyc(4);
  endtask

  task automatic rd(int a, int exp, string tag);
    cyc(1); addr = AW'(a); cs_n = 0; oe_n = 0;
    cyc(4); @(negedge clk); #1;
    chk(tag, dq_out, exp);
    cyc(1); cs_n = 1; oe_n = 1;
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    @(negedge clk); chk("R11 oe after reset", dq_oe, 0);
    rd(5, 8'h00, "R11 array zero");
    // R4 page with overwrite
    wr(8'h10, 8'hA5); wr(8'h11, 8'h3C); wr(8'h13, 8'h7F); wr(8'h11, 8'h44);
    rd(8'h10, 8'h00, "R2 buffered not visible");
    cyc(30);
    rd(8'h55, 8'h80, "R8 bit7 inverted, R9 first toggle 0");
    rd(8'h10, 8'hC0, "R9 toggle second read");
    rd(8'h10, 8'h80, "R9 toggle third read");
    wr(8'h20, 8'h5A);
    cyc(130);
    rd(8'h10, 8'hA5, "R4 byte stored");
    rd(8'h11, 8'h44, "R4 overwrite kept last");
    rd(8'h13, 8'h7F, "R4 offset 3");
    rd(8'h12, 8'h00, "R4 unloaded offset untouched");
    rd(8'h20, 8'h00, "R7 write during programming ignored");
    // R5 cross-page write ignored
    wr(8'h28, 8'h81); wr(8'h30, 8'h99); wr(8'h2F, 8'h12);
    cyc(30);
    rd(8'h28, 8'h80, "R8 polling last byte 0x12");
    cyc(130);
    rd(8'h28, 8'h81, "R5 same page stored");
    rd(8'h2F, 8'h12, "R5 same page stored 2");
    rd(8'h30, 8'h00, "R5 other page ignored");
    // R8 last byte with bit7 set
    wr(8'h40, 8'hF0); cyc(30);
    rd(8'h40, 8'h00, "R8 bit7 inverse of 1");
    cyc(130);
    rd(8'h40, 8'hF0, "R7 committed after programming");
    // full page
    for (int k = 0; k < PN; k++) wr(8'h48 + k, 8'h11 * (k + 1));
    cyc(170);
    for (int k = 0; k < PN; k++) rd(8'h48 + k, (8'h11 * (k + 1)) & 8'hFF, "R4 full page");
    // R10 lock
    lock = 1; wr(8'h60, 8'h55); cyc(40);
    rd(8'h60, 8'h00, "R10 locked read shows array");
    cyc(140); lock = 0;
    rd(8'h60, 8'h00, "R10 locked write dropped");
    // R3 all strobes low is not a write
    wr(8'h70, 8'h66, 1'b1); cyc(170);
    rd(8'h70, 8'h00, "R3 oe low blocks write");
    // R6 gap longer than window splits pages
    wr(8'h78, 8'h21); cyc(WIN + 140);
    wr(8'h79, 8'h22); cyc(WIN + 140);
    rd(8'h78, 8'h21, "R6 first page alone");
    rd(8'h79, 8'h22, "R6 second page alone");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule